// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block is the host side of a byte-wide, pin-driven flash programming session. A start command brings in a byte count and an erase request. The sequencer raises the target's reset line, which clears the target's internal address counter. If erase was requested, it runs a timed bulk erase. It then takes data bytes one at a time over a valid/ready stream.

For each byte it does the following in order:
- drives the byte and pulses the program strobe;
- waits until the target reports that the write has finished;
- drops the high-voltage enable and reads the byte back in read mode;
- pulses the address-advance clock before it accepts the next byte.

The first mismatch or write timeout ends the session. The sequencer records the address of the failing byte. On every exit the target is shut down in a fixed order: the advance clock is brought low first, then the reset line. Completion is detected in one of two ways, chosen by a parameter. The first waits for the ready/busy pin to return high. The second uses data polling: it waits until the top data bit read back is no longer the complement of the bit that was written.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the target pins idle: `tgt_rst`=0, `tgt_hv`=0, `tgt_strobe_n`=1, `tgt_adv`=0. The flags `busy`, `done`, `err_verify` and `err_timeout` are 0, and `s_ready` is 0.
- R2: A start with a non-zero count raises `tgt_rst` from 0 to 1 before any strobe, so the first byte goes to address 0. `tgt_hv` is high only while `tgt_rst` is high.
- R3: When `cmd_erase` is set at start, the strobe is held low with `tgt_mode`=2'b10 and `tgt_hv`=1 for exactly ERASE_CYC cycles, and this happens before the first byte is written.
- R4: Each byte is taken on a cycle with `s_valid` and `s_ready` both high. It is then driven on `tgt_dout` with `tgt_doe`=1, `tgt_hv`=1 and `tgt_mode`=2'b01, and the strobe goes low once for exactly PULSE_CYC cycles.
- R5: After a hold-off of SETTLE_CYC cycles, a write counts as complete under one of two rules. With USE_POLL=0, it completes when `tgt_rdy` is 1. With USE_POLL=1, it completes when `tgt_din[7]` equals bit 7 of the written byte.
- R6: If a write has not completed within TIMEOUT_CYC cycles, the sequencer sets `err_timeout`, latches the byte's address in `err_addr`, and stops without writing further bytes.
- R7: Verify happens with `tgt_hv`=0 and `tgt_mode`=2'b00, after SETTLE_CYC cycles. On the first byte that differs from the written value, the sequencer sets `err_verify`, latches that address in `err_addr`, and accepts no more bytes.
- R8: Between consecutive bytes there is exactly one `tgt_adv` pulse, and there is none after the last byte. A job of N bytes therefore writes addresses 0 to N-1 and produces N-1 advance pulses.
- R9: On shutdown `tgt_adv` is already low for at least one cycle before `tgt_rst` falls. `done` is then set, and all flags hold until the next start. A start with count 0 sets `done` without raising `tgt_rst`.
- R10: `s_ready` is high only while the sequencer waits for a byte. It is never high during a strobe, an advance pulse, or when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | begin a job (accepted while idle) |
| cmd_erase | input | 1 | run bulk erase before programming |
| byte_count | input | ADDR_W+1 | number of bytes to program |
| s_valid | input | 1 | stream byte valid |
| s_data | input | DATA_W | stream byte |
| s_ready | output | 1 | sequencer accepts a byte |
| busy | output | 1 | job in progress |
| done | output | 1 | job finished (sticky) |
| err_verify | output | 1 | read-back mismatch (sticky) |
| err_timeout | output | 1 | write completion timed out (sticky) |
| err_addr | output | ADDR_W | address of the failing byte |
| tgt_rst | output | 1 | target reset line; rising edge clears its address |
| tgt_hv | output | 1 | high-voltage programming enable |
| tgt_mode | output | 2 | 00 read code, 01 program, 10 erase |
| tgt_strobe_n | output | 1 | active-low program/erase strobe |
| tgt_adv | output | 1 | address-advance clock |
| tgt_dout | output | DATA_W | data to target |
| tgt_doe | output | 1 | data output enable |
| tgt_din | input | DATA_W | data read from target |
| tgt_rdy | input | 1 | target ready (1) / busy (0) |

## Verification
The bench runs several jobs against a behavioural target whose cells only clear bits, so writing over stored data without an erase produces a real mismatch.
- An erase-then-program run with ascending bytes separates a correct address walk and advance count from skipped or doubled pulses.
- A polling-mode run alternates bit 7 between 1 and 0, which shows whether the polling compare follows the written bit.
- A rewrite without erase must stop at the byte that cannot be stored and must not accept the byte after it.
- A zero-length start and a target that never finishes cover the trivial exit and the timeout exit.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RST_RISE,
    S_ERASE,
    S_ERASE_REC,
    S_WAIT_DATA,
    S_SETUP,
    S_STROBE,
    S_HOLDOFF,
    S_WAIT_DONE,
    S_VERIFY,
    S_ADV_HI,
    S_ADV_LO,
    S_SHUT_ADV
  } seq_state_e;

  localparam logic [1:0] MODE_READ  = 2'b00;
  localparam logic [1:0] MODE_PROG  = 2'b01;
  localparam logic [1:0] MODE_ERASE = 2'b10;

endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R6: an expired interval stays expired until reloaded
  a_r6_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/prog_addr_ctr.sv
module prog_addr_ctr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (clr)
      addr_d = '0;
    else if (inc)
      addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_q <= '0;
    else
      addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R8: each advance moves the shadow address by exactly one
  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/prog_cmpl_detect.sv
module prog_cmpl_detect #(
  parameter bit USE_POLL = 1'b0
) (
  input  logic rdy,
  input  logic rd_msb,
  input  logic wr_msb,
  output logic complete
);

  generate
    if (USE_POLL) begin : g_poll
      assign complete = (rd_msb == wr_msb);
    end else begin : g_rdy
      logic unused_msb;
      assign unused_msb = rd_msb ^ wr_msb;
      assign complete = rdy;
    end
  endgenerate

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SETTLE_CYC  = 4,
  parameter int PULSE_CYC   = 8,
  parameter int ERASE_CYC   = 1_000_000,
  parameter int TIMEOUT_CYC = 200_000,
  parameter bit USE_POLL    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_erase,
  input  logic [ADDR_W:0]   byte_count,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              busy,
  output logic              done,
  output logic              err_verify,
  output logic              err_timeout,
  output logic [ADDR_W-1:0] err_addr,
  output logic              tgt_rst,
  output logic              tgt_hv,
  output logic [1:0]        tgt_mode,
  output logic              tgt_strobe_n,
  output logic              tgt_adv,
  output logic [DATA_W-1:0] tgt_dout,
  output logic              tgt_doe,
  input  logic [DATA_W-1:0] tgt_din,
  input  logic              tgt_rdy
);

  localparam int CNT_W = ADDR_W + 1;
  localparam int T_A   = (ERASE_CYC > TIMEOUT_CYC) ? ERASE_CYC : TIMEOUT_CYC;
  localparam int T_B   = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int TW    = $clog2(T_MAX + 1);

  seq_state_e          state_q, state_d;
  logic [CNT_W-1:0]    count_q;
  logic                erase_q;
  logic [DATA_W-1:0]   wr_q;
  logic                done_q, verr_q, terr_q;
  logic [ADDR_W-1:0]   eaddr_q;

  logic                t_load, t_zero;
  logic [TW-1:0]       t_val;
  logic                a_clr, a_inc;
  logic [ADDR_W-1:0]   addr;
  logic                complete, is_last;
  logic                start_acc, take_byte, fin, set_verr, set_terr;

  prog_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero));

  prog_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(a_clr), .inc(a_inc), .addr(addr));

  prog_cmpl_detect #(.USE_POLL(USE_POLL)) u_cmpl (
    .rdy(tgt_rdy), .rd_msb(tgt_din[DATA_W-1]), .wr_msb(wr_q[DATA_W-1]),
    .complete(complete));

  assign is_last = ({1'b0, addr} == (count_q - 1'b1));

  // next-state logic
  always_comb begin
    state_d   = state_q;
    start_acc = 1'b0;
    take_byte = 1'b0;
    fin       = 1'b0;
    set_verr  = 1'b0;
    set_terr  = 1'b0;
    a_inc     = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        start_acc = 1'b1;
        if (byte_count == '0) fin = 1'b1;
        else                  state_d = S_RST_RISE;
      end
      S_RST_RISE:  if (t_zero) state_d = erase_q ? S_ERASE : S_WAIT_DATA;
      S_ERASE:     if (t_zero) state_d = S_ERASE_REC;
      S_ERASE_REC: if (t_zero) state_d = S_WAIT_DATA;
      S_WAIT_DATA: if (s_valid) begin
        take_byte = 1'b1;
        state_d   = S_SETUP;
      end
      S_SETUP:     if (t_zero) state_d = S_STROBE;
      S_STROBE:    if (t_zero) state_d = S_HOLDOFF;
      S_HOLDOFF:   if (t_zero) state_d = S_WAIT_DONE;
      S_WAIT_DONE: if (complete) state_d = S_VERIFY;
                   else if (t_zero) begin
                     set_terr = 1'b1;
                     state_d  = S_SHUT_ADV;
                   end
      S_VERIFY: if (t_zero) begin
        if (tgt_din != wr_q) begin
          set_verr = 1'b1;
          state_d  = S_SHUT_ADV;
        end else if (is_last) state_d = S_SHUT_ADV;
        else                  state_d = S_ADV_HI;
      end
      S_ADV_HI: if (t_zero) state_d = S_ADV_LO;
      S_ADV_LO: if (t_zero) begin
        a_inc   = 1'b1;
        state_d = S_WAIT_DATA;
      end
      S_SHUT_ADV: if (t_zero) begin
        fin     = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // interval selection on every state change
  always_comb begin
    t_load = (state_d != state_q);
    unique case (state_d)
      S_ERASE:     t_val = TW'(ERASE_CYC - 1);
      S_STROBE,
      S_ADV_HI:    t_val = TW'(PULSE_CYC - 1);
      S_WAIT_DONE: t_val = TW'(TIMEOUT_CYC - 1);
      default:     t_val = TW'(SETTLE_CYC - 1);
    endcase
  end

  assign a_clr = start_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      count_q <= '0;
      erase_q <= 1'b0;
      wr_q    <= '0;
      done_q  <= 1'b0;
      verr_q  <= 1'b0;
      terr_q  <= 1'b0;
      eaddr_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_acc) begin
        count_q <= byte_count;
        erase_q <= cmd_erase;
        done_q  <= 1'b0;
        verr_q  <= 1'b0;
        terr_q  <= 1'b0;
        eaddr_q <= '0;
      end
      if (take_byte) wr_q <= s_data;
      if (set_verr || set_terr) eaddr_q <= addr;
      if (set_verr) verr_q <= 1'b1;
      if (set_terr) terr_q <= 1'b1;
      if (fin)      done_q <= 1'b1;
    end
  end

  // target pin decode
  always_comb begin
    tgt_hv   = 1'b0;
    tgt_mode = MODE_READ;
    tgt_doe  = 1'b0;
    unique case (state_q)
      S_ERASE: begin
        tgt_hv   = 1'b1;
        tgt_mode = MODE_ERASE;
      end
      S_SETUP, S_STROBE, S_HOLDOFF: begin
        tgt_hv   = 1'b1;
        tgt_mode = MODE_PROG;
        tgt_doe  = 1'b1;
      end
      S_WAIT_DONE: begin
        tgt_hv   = 1'b1;
        tgt_mode = MODE_PROG;
      end
      default: ;
    endcase
  end

  assign tgt_rst      = (state_q != S_IDLE);
  assign tgt_strobe_n = !((state_q == S_ERASE) || (state_q == S_STROBE));
  assign tgt_adv      = (state_q == S_ADV_HI);
  assign tgt_dout     = wr_q;
  assign s_ready      = (state_q == S_WAIT_DATA);
  assign busy         = (state_q != S_IDLE);
  assign done         = done_q;
  assign err_verify   = verr_q;
  assign err_timeout  = terr_q;
  assign err_addr     = eaddr_q;

  a_r2_hv_needs_rst: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_hv |-> tgt_rst);
  a_r4_strobe_under_hv: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_strobe_n |-> tgt_hv);
  a_r8_adv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_adv |-> (tgt_strobe_n && !tgt_hv));
  a_r9_adv_low_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_rst) |-> (!tgt_adv && !$past(tgt_adv)));
  a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (tgt_strobe_n && !tgt_adv && tgt_rst));

endmodule

// File: tb/flash_prog_seq_test.sv
module flash_tgt_model #(
  parameter logic [7:0] INIT       = 8'h00,
  parameter int         BUSY       = 20,
  parameter int         ERASE_NEED = 40
) (
  input  logic       clk,
  input  logic       rst_line,
  input  logic       hv,
  input  logic [1:0] mode,
  input  logic       strobe_n,
  input  logic       adv,
  input  logic [7:0] dout,
  input  logic       doe,
  input  logic       hang,
  output logic [7:0] din,
  output logic       rdy,
  output logic       wr_evt,
  output logic [10:0] wr_addr,
  output logic [7:0] wr_data
);
  logic [7:0]  mem [2048];
  logic [10:0] addr = '0;
  logic [10:0] wa = '0;
  logic [7:0]  lat = '0;
  int          busy_cnt = 0;
  int          low_cnt = 0;
  int          erase_cnt = 0;
  logic        p_rst = 1'b0, p_adv = 1'b0, p_stb = 1'b1;

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = INIT;
    wr_evt = 1'b0; wr_addr = '0; wr_data = '0;
  end

  always @(posedge clk) begin
    p_rst  <= rst_line;
    p_adv  <= adv;
    p_stb  <= strobe_n;
    wr_evt <= 1'b0;
    if (rst_line && !p_rst) addr <= '0;
    else if (adv && !p_adv) addr <= addr + 1'b1;
    if (!strobe_n && p_stb && hv && mode == 2'b01 && doe) begin
      lat      <= dout;
      wa       <= addr;
      busy_cnt <= BUSY;
    end else if (busy_cnt != 0 && !hang) begin
      busy_cnt <= busy_cnt - 1;
      if (busy_cnt == 1) begin
        mem[wa] <= mem[wa] & lat;
        wr_evt  <= 1'b1;
        wr_addr <= wa;
        wr_data <= lat;
      end
    end
    if (!strobe_n && hv && mode == 2'b10) low_cnt <= low_cnt + 1;
    else if (strobe_n && !p_stb && low_cnt >= ERASE_NEED) begin
      for (int i = 0; i < 2048; i++) mem[i] <= 8'hFF;
      erase_cnt <= erase_cnt + 1;
      low_cnt   <= 0;
    end else if (strobe_n) low_cnt <= 0;
  end

  assign rdy = (busy_cnt == 0);
  assign din = (busy_cnt != 0) ? {~lat[7], lat[6:0]} :
               (((mode == 2'b00) && !hv) || (mode == 2'b01)) ? mem[addr] : 8'h00;
endmodule

module flash_prog_seq_test;
  localparam int SETTLE = 3, PULSE = 4, ERASE = 50, TOUT = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start_v [2];
  logic        erase_v [2];
  logic [11:0] cnt_v [2];
  logic        s_valid_v [2];
  logic [7:0]  s_data_v [2];
  logic        s_ready_v [2], busy_v [2], done_v [2], ev_v [2], et_v [2];
  logic [10:0] eaddr_v [2];
  logic        t_rst [2], t_hv [2], t_stb [2], t_adv [2], t_doe [2], t_rdy [2];
  logic [1:0]  t_mode [2];
  logic [7:0]  t_dout [2], t_din [2];
  logic        hang_v [2];
  logic        wr_evt [2];
  logic [10:0] wr_addr [2];
  logic [7:0]  wr_data [2];

  flash_prog_seq #(.SETTLE_CYC(SETTLE), .PULSE_CYC(PULSE), .ERASE_CYC(ERASE),
                   .TIMEOUT_CYC(TOUT), .USE_POLL(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start_v[0]), .cmd_erase(erase_v[0]),
    .byte_count(cnt_v[0]), .s_valid(s_valid_v[0]), .s_data(s_data_v[0]),
    .s_ready(s_ready_v[0]), .busy(busy_v[0]), .done(done_v[0]),
    .err_verify(ev_v[0]), .err_timeout(et_v[0]), .err_addr(eaddr_v[0]),
    .tgt_rst(t_rst[0]), .tgt_hv(t_hv[0]), .tgt_mode(t_mode[0]),
    .tgt_strobe_n(t_stb[0]), .tgt_adv(t_adv[0]), .tgt_dout(t_dout[0]),
    .tgt_doe(t_doe[0]), .tgt_din(t_din[0]), .tgt_rdy(t_rdy[0]));

  flash_prog_seq #(.SETTLE_CYC(SETTLE), .PULSE_CYC(PULSE), .ERASE_CYC(ERASE),
                   .TIMEOUT_CYC(TOUT), .USE_POLL(1'b1)) uut_poll (
    .clk(clk), .rst_n(rst_n), .start(start_v[1]), .cmd_erase(erase_v[1]),
    .byte_count(cnt_v[1]), .s_valid(s_valid_v[1]), .s_data(s_data_v[1]),
    .s_ready(s_ready_v[1]), .busy(busy_v[1]), .done(done_v[1]),
    .err_verify(ev_v[1]), .err_timeout(et_v[1]), .err_addr(eaddr_v[1]),
    .tgt_rst(t_rst[1]), .tgt_hv(t_hv[1]), .tgt_mode(t_mode[1]),
    .tgt_strobe_n(t_stb[1]), .tgt_adv(t_adv[1]), .tgt_dout(t_dout[1]),
    .tgt_doe(t_doe[1]), .tgt_din(t_din[1]), .tgt_rdy(t_rdy[1]));

  flash_tgt_model #(.INIT(8'h00)) m0 (
    .clk(clk), .rst_line(t_rst[0]), .hv(t_hv[0]), .mode(t_mode[0]),
    .strobe_n(t_stb[0]), .adv(t_adv[0]), .dout(t_dout[0]), .doe(t_doe[0]),
    .hang(hang_v[0]), .din(t_din[0]), .rdy(t_rdy[0]), .wr_evt(wr_evt[0]),
    .wr_addr(wr_addr[0]), .wr_data(wr_data[0]));

  flash_tgt_model #(.INIT(8'hFF)) m1 (
    .clk(clk), .rst_line(t_rst[1]), .hv(t_hv[1]), .mode(t_mode[1]),
    .strobe_n(t_stb[1]), .adv(t_adv[1]), .dout(t_dout[1]), .doe(t_doe[1]),
    .hang(hang_v[1]), .din(t_din[1]), .rdy(t_rdy[1]), .wr_evt(wr_evt[1]),
    .wr_addr(wr_addr[1]), .wr_data(wr_data[1]));

  int n_chk = 0, n_err = 0;
  logic [18:0] q0 [$];
  logic [18:0] q1 [$];
  int adv_rise [2], rst_rise [2], wr_cnt [2], low_len [2];
  logic p_rst [2], p_adv [2], p_stb [2];
  logic [1:0] low_mode [2];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor and pin-level observers
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        if (wr_evt[k]) begin
          logic [18:0] item;
          wr_cnt[k]++;
          if ((k == 0 ? q0.size() : q1.size()) == 0)
            chk(1'b0, "R4 unexpected write", int'(wr_addr[k]), 0);
          else begin
            item = (k == 0) ? q0.pop_front() : q1.pop_front();
            chk({wr_addr[k], wr_data[k]} == item, "R2/R8 write addr+data",
                int'({wr_addr[k], wr_data[k]}), int'(item));
          end
        end
        if (t_adv[k] && !p_adv[k]) adv_rise[k]++;
        if (t_rst[k] && !p_rst[k]) rst_rise[k]++;
        if (!t_rst[k] && p_rst[k])
          chk(!t_adv[k] && !p_adv[k], "R9 adv low before rst falls", int'(t_adv[k]), 0);
        if (!t_stb[k]) begin
          low_len[k]++;
          low_mode[k] = t_mode[k];
        end else if (!p_stb[k]) begin
          if (low_mode[k] == 2'b10)
            chk(low_len[k] == ERASE, "R3 erase strobe width", low_len[k], ERASE);
          else
            chk(low_len[k] == PULSE, "R4 program strobe width", low_len[k], PULSE);
          low_len[k] = 0;
        end
        p_rst[k] = t_rst[k];
        p_adv[k] = t_adv[k];
        p_stb[k] = t_stb[k];
      end
    end
  end

  function automatic logic [7:0] gen(input int pat, input int idx);
    case (pat)
      0:       gen = 8'h10 + 8'(idx);
      1:       gen = idx[0] ? (8'h7F - 8'(idx)) : (8'h80 + 8'(idx));
      default: gen = (idx == 2) ? 8'hFF : (8'h10 + 8'(idx));
    endcase
  endfunction

  task automatic run_job(input int k, input bit erase, input int count,
                         input int pat, output int fed);
    fed = 0;
    @(negedge clk);
    start_v[k] = 1'b1; erase_v[k] = erase; cnt_v[k] = 12'(count);
    @(negedge clk);
    start_v[k] = 1'b0;
    while (!done_v[k]) begin
      if (s_ready_v[k] && fed < count) begin
        s_data_v[k]  = gen(pat, fed);
        s_valid_v[k] = 1'b1;
        if (k == 0) q0.push_back({11'(fed), gen(pat, fed)});
        else        q1.push_back({11'(fed), gen(pat, fed)});
        fed++;
        @(negedge clk);
        s_valid_v[k] = 1'b0;
      end else @(negedge clk);
    end
  endtask

  task automatic main_seq;
    int fed, a0, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(t_rst[0] == 0 && t_hv[0] == 0, "R1 rst/hv idle", int'({t_rst[0], t_hv[0]}), 0);
    chk(t_stb[0] == 1 && t_adv[0] == 0, "R1 strobe/adv idle", int'({t_stb[0], t_adv[0]}), 2);
    chk(busy_v[0] == 0 && done_v[0] == 0, "R1 busy/done", int'({busy_v[0], done_v[0]}), 0);
    chk(ev_v[0] == 0 && et_v[0] == 0, "R1 err flags", int'({ev_v[0], et_v[0]}), 0);
    chk(s_ready_v[0] == 0 && s_ready_v[1] == 0, "R10 ready idle", int'(s_ready_v[0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(t_rst[1] == 0 && busy_v[1] == 0, "R1 poll idle", int'({t_rst[1], busy_v[1]}), 0);

    // job A: erase + 5 ascending bytes, ready/busy completion
    a0 = adv_rise[0];
    run_job(0, 1'b1, 5, 0, fed);
    chk(done_v[0] && !ev_v[0] && !et_v[0], "R5 job A clean finish",
        int'({done_v[0], ev_v[0], et_v[0]}), 4);
    chk(m0.erase_cnt == 1, "R3 erase executed", m0.erase_cnt, 1);
    chk(wr_cnt[0] == 5 && q0.size() == 0, "R4 five writes", wr_cnt[0], 5);
    chk(adv_rise[0] - a0 == 4, "R8 advance pulses", adv_rise[0] - a0, 4);
    for (int i = 0; i < 5; i++)
      chk(m0.mem[i] == 8'h10 + 8'(i), "R7 stored byte", int'(m0.mem[i]), 8'h10 + i);
    chk(m0.mem[5] == 8'hFF, "R3 rest blank", int'(m0.mem[5]), 8'hFF);
    chk(!s_ready_v[0] && !t_rst[0], "R10/R9 idle after job", int'({s_ready_v[0], t_rst[0]}), 0);

    // job B: polling completion, bit 7 alternating
    a0 = adv_rise[1];
    run_job(1, 1'b0, 6, 1, fed);
    chk(done_v[1] && !ev_v[1] && !et_v[1], "R5 poll job finish",
        int'({done_v[1], ev_v[1], et_v[1]}), 4);
    chk(wr_cnt[1] == 6 && q1.size() == 0, "R5 poll six writes", wr_cnt[1], 6);
    chk(adv_rise[1] - a0 == 5, "R8 poll advance pulses", adv_rise[1] - a0, 5);
    chk(m1.mem[3] == 8'h7C, "R5 poll stored byte", int'(m1.mem[3]), 8'h7C);

    // job C: rewrite without erase, byte 2 cannot be stored
    run_job(0, 1'b0, 4, 2, fed);
    chk(ev_v[0] && !et_v[0], "R7 verify error flag", int'({ev_v[0], et_v[0]}), 2);
    chk(eaddr_v[0] == 11'd2, "R7 failing address", int'(eaddr_v[0]), 2);
    chk(fed == 3, "R7 no byte after mismatch", fed, 3);
    chk(wr_cnt[0] == 8 && q0.size() == 0, "R7 write count", wr_cnt[0], 8);
    chk(done_v[0] && !t_rst[0], "R9 shutdown after error", int'({done_v[0], t_rst[0]}), 2);

    // job D: zero count
    r0 = rst_rise[1];
    run_job(1, 1'b0, 0, 0, fed);
    chk(done_v[1] && !ev_v[1] && !et_v[1], "R9 zero count done",
        int'({done_v[1], ev_v[1], et_v[1]}), 4);
    chk(rst_rise[1] == r0, "R9 zero count leaves rst low", rst_rise[1] - r0, 0);

    // job F: erase on polling instance, 3 bytes
    run_job(1, 1'b1, 3, 0, fed);
    chk(done_v[1] && !ev_v[1] && !et_v[1], "R3 poll erase job",
        int'({done_v[1], ev_v[1], et_v[1]}), 4);
    chk(m1.erase_cnt == 1 && m1.mem[3] == 8'hFF, "R3 erase cleared old data",
        int'(m1.mem[3]), 8'hFF);
    chk(rst_rise[1] == r0 + 1, "R2 reset line raised once", rst_rise[1] - r0, 1);

    // job E: target never finishes
    hang_v[0] = 1'b1;
    run_job(0, 1'b0, 2, 0, fed);
    chk(et_v[0] && !ev_v[0], "R6 timeout flag", int'({et_v[0], ev_v[0]}), 2);
    chk(eaddr_v[0] == 11'd0, "R6 timeout address", int'(eaddr_v[0]), 0);
    chk(fed == 1 && q0.size() == 1, "R6 stops after timeout", fed, 1);
    q0.delete();
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      start_v[k] = 0; erase_v[k] = 0; cnt_v[k] = '0; s_valid_v[k] = 0;
      s_data_v[k] = '0; hang_v[k] = 0; adv_rise[k] = 0; rst_rise[k] = 0;
      wr_cnt[k] = 0; low_len[k] = 0; p_rst[k] = 0; p_adv[k] = 0; p_stb[k] = 1;
      low_mode[k] = 2'b00;
    end
    fork
      main_seq();
      begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule